// File: doc/BRIEF.md
# Four-Register Control File on a Split Read/Write Register Bus

This block is a small register file that user logic places behind a simple internal bus. The bus has a write channel and a separate read channel, and each moves one transfer at a time. The block decodes the address of each transfer and applies byte-masked writes. It returns read data one clock after the request, through registers, so the read path is never combinational. It also exposes its register contents and its hardware load ports to the logic around it.

The map holds four registers. `WORD` at 0x0000 is a full-width read/write word that hardware can also load. `CONFIG` at 0x0004 is a 16-bit read/write setting with a nonzero reset value. `STATE` at 0x0008 is an 8-bit read-only view of a hardware input. `KICK` at 0x0100 is a one-bit write-only strobe that clears itself. Every field starts at bit 0 of its register. A read from any other address returns a fill value set by a parameter.

Top module: `ctl_regfile`

## Requirements
- R1: While `rst_n` is low, `word_q` is 0, `cfg_q` is the value of `CFG_RST` (0x0100 by default), and `kick_pulse`, `wr_ready` and `rd_valid` are all 0.
- R2: `rd_valid` rises exactly one clock after `rd_en` is first seen high. `rd_data` is valid while `rd_valid` is high. `rd_valid` is never high in the first cycle of a request.
- R3: `wr_ready` rises one clock after `wr_en` is first seen high and stays high for a single cycle. The write takes effect at the clock edge that ends that cycle.
- R4: Bit i of `wr_strb` enables byte i (bits 8i+7..8i) of `wr_data`. Bytes whose strobe bit is 0 keep their old value. For example, strobe 0x6 changes bytes 1 and 2 only.
- R5: When `word_hw_ld` is high and no software write to 0x0000 completes in that cycle, `word_q` takes the value of `word_hw_in` at the next clock.
- R6: When a software write to 0x0000 completes in the same cycle that `word_hw_ld` is high, the software data wins for the enabled bytes.
- R7: `CONFIG` at 0x0004 stores bits 15..0 of the write data. A read returns those bits with bits 31..16 set to 0. A write to any other address leaves `cfg_q` unchanged.
- R8: A read of 0x0008 returns `state_hw_in` in bits 7..0, with 0 above. A write to 0x0008 changes no register.
- R9: Writing 1 to bit 0 of 0x0100 with strobe bit 0 set drives `kick_pulse` high for exactly the one cycle after the write. Writing 0 to that bit gives no pulse. A read of 0x0100 returns 0.
- R10: A read of an address outside the map returns `RD_FILLER` (0 by default). A write to such an address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | DATA_W | Write data |
| wr_en | input | 1 | Write request, held until wr_ready |
| wr_strb | input | DATA_W/8 | Byte enables for the write |
| wr_ready | output | 1 | Write completes at the end of this cycle |
| rd_addr | input | ADDR_W | Read byte address |
| rd_en | input | 1 | Read request, held until rd_valid |
| rd_data | output | DATA_W | Registered read data |
| rd_valid | output | 1 | Read data valid |
| word_hw_in | input | DATA_W | Hardware load value for WORD |
| word_hw_ld | input | 1 | Load enable for WORD |
| word_q | output | DATA_W | Current WORD value |
| cfg_q | output | 16 | Current CONFIG value |
| state_hw_in | input | 8 | Hardware status read through STATE |
| kick_pulse | output | 1 | One-cycle strobe from KICK |

## Verification
Two functions can land on `WORD` in the same cycle: a completing software write and the hardware load. The bench raises `word_hw_ld`, with a different value on `word_hw_in`, for the whole write handshake to 0x0000, so that the load is still active on the commit edge. It then requires that `word_q` holds the software data, and an assertion checks the same rule on every full-strobe write. A separate test applies the load with the bus idle, to show that the load path works by itself.

// File: rtl/ctl_regfile_pkg.sv
package ctl_regfile_pkg;

  // Byte offsets of the mapped registers
  localparam int unsigned OFS_WORD  = 32'h0000;
  localparam int unsigned OFS_CFG   = 32'h0004;
  localparam int unsigned OFS_STATE = 32'h0008;
  localparam int unsigned OFS_KICK  = 32'h0100;

  // Field widths fixed by the map
  localparam int unsigned CFG_W   = 16;
  localparam int unsigned STATE_W = 8;

  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_WORD  = 3'd1,
    SEL_CFG   = 3'd2,
    SEL_STATE = 3'd3,
    SEL_KICK  = 3'd4
  } reg_sel_e;

endpackage

// File: rtl/ctl_regfile_dec.sv
module ctl_regfile_dec
  import ctl_regfile_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);

  always_comb begin
    if (addr == ADDR_W'(OFS_WORD))       sel = SEL_WORD;
    else if (addr == ADDR_W'(OFS_CFG))   sel = SEL_CFG;
    else if (addr == ADDR_W'(OFS_STATE)) sel = SEL_STATE;
    else if (addr == ADDR_W'(OFS_KICK))  sel = SEL_KICK;
    else                                 sel = SEL_NONE;
  end

endmodule

// File: rtl/ctl_regfile_wr.sv
module ctl_regfile_wr
  import ctl_regfile_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [STRB_W-1:0] wr_strb,
  output logic              wr_ready,
  output logic              commit,
  output reg_sel_e          sel,
  output logic [DATA_W-1:0] bit_mask
);

  logic ready_q, ready_d;

  ctl_regfile_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr (wr_addr),
    .sel  (sel)
  );

  // Expand each strobe bit over its byte lane
  for (genvar b = 0; b < STRB_W; b++) begin : g_lane
    assign bit_mask[8*b +: 8] = {8{wr_strb[b]}};
  end

  // One-cycle ready after the request is first seen
  always_comb begin
    ready_d = wr_en & ~ready_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= ready_d;
  end

  assign wr_ready = ready_q;
  assign commit   = wr_en & ready_q;

endmodule

// File: rtl/ctl_regfile_bank.sv
module ctl_regfile_bank
  import ctl_regfile_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [CFG_W-1:0] CFG_RST = 16'h0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] bit_mask,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] word_hw_in,
  input  logic              word_hw_ld,
  output logic [DATA_W-1:0] word_q,
  output logic [CFG_W-1:0]  cfg_q,
  output logic              kick_q
);

  logic [DATA_W-1:0] word_d;
  logic [CFG_W-1:0]  cfg_d;
  logic              kick_d;
  logic              word_en, cfg_en;
  logic              hit_word, hit_cfg, hit_kick;

  assign hit_word = commit && (sel == SEL_WORD);
  assign hit_cfg  = commit && (sel == SEL_CFG);
  assign hit_kick = commit && (sel == SEL_KICK);

  // WORD: software write wins over the hardware load
  always_comb begin
    word_en = hit_word | word_hw_ld;
    if (hit_word) word_d = (word_q & ~bit_mask) | (wr_data & bit_mask);
    else          word_d = word_hw_in;
  end

  // CONFIG: low lanes of the bus only
  always_comb begin
    cfg_en = hit_cfg;
    cfg_d  = (cfg_q & ~bit_mask[CFG_W-1:0]) | (wr_data[CFG_W-1:0] & bit_mask[CFG_W-1:0]);
  end

  // KICK: set by a written 1, gone on the next clock
  always_comb begin
    kick_d = hit_kick & bit_mask[0] & wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= word_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= CFG_RST;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) kick_q <= 1'b0;
    else        kick_q <= kick_d;
  end

endmodule

// File: rtl/ctl_regfile_rd.sv
module ctl_regfile_rd
  import ctl_regfile_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] RD_FILLER = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic [DATA_W-1:0]  word_q,
  input  logic [CFG_W-1:0]   cfg_q,
  input  logic [STATE_W-1:0] state_hw_in,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_valid
);

  reg_sel_e          sel;
  logic [DATA_W-1:0] data_d, data_q;
  logic              valid_d, valid_q, load_en;

  ctl_regfile_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr (rd_addr),
    .sel  (sel)
  );

  always_comb begin
    unique case (sel)
      SEL_WORD:  data_d = word_q;
      SEL_CFG:   data_d = DATA_W'(cfg_q);
      SEL_STATE: data_d = DATA_W'(state_hw_in);
      SEL_KICK:  data_d = '0;
      default:   data_d = RD_FILLER;
    endcase
  end

  always_comb begin
    valid_d = rd_en & ~valid_q;
    load_en = valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (load_en) data_q <= data_d;
  end

  assign rd_data  = data_q;
  assign rd_valid = valid_q;

endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile
  import ctl_regfile_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter logic [15:0] CFG_RST = 16'h0100,
  parameter logic [DATA_W-1:0] RD_FILLER = '0,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en,
  input  logic [STRB_W-1:0] wr_strb,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic [DATA_W-1:0] word_hw_in,
  input  logic              word_hw_ld,
  output logic [DATA_W-1:0] word_q,
  output logic [15:0]       cfg_q,
  input  logic [7:0]        state_hw_in,
  output logic              kick_pulse
);

  logic              commit;
  reg_sel_e          wsel;
  logic [DATA_W-1:0] bit_mask;

  ctl_regfile_wr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_strb  (wr_strb),
    .wr_ready (wr_ready),
    .commit   (commit),
    .sel      (wsel),
    .bit_mask (bit_mask)
  );

  ctl_regfile_bank #(.DATA_W(DATA_W), .CFG_RST(CFG_RST)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (commit),
    .sel        (wsel),
    .bit_mask   (bit_mask),
    .wr_data    (wr_data),
    .word_hw_in (word_hw_in),
    .word_hw_ld (word_hw_ld),
    .word_q     (word_q),
    .cfg_q      (cfg_q),
    .kick_q     (kick_pulse)
  );

  ctl_regfile_rd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_FILLER(RD_FILLER)) u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en       (rd_en),
    .rd_addr     (rd_addr),
    .word_q      (word_q),
    .cfg_q       (cfg_q),
    .state_hw_in (state_hw_in),
    .rd_data     (rd_data),
    .rd_valid    (rd_valid)
  );

endmodule

// File: rtl/ctl_regfile_chk.sv
module ctl_regfile_chk
  import ctl_regfile_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_en,
  input logic [STRB_W-1:0] wr_strb,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic [DATA_W-1:0] word_hw_in,
  input logic              word_hw_ld,
  input logic [DATA_W-1:0] word_q,
  input logic [15:0]       cfg_q,
  input logic              kick_pulse
);

  logic wr_word, wr_cfg;
  assign wr_word = wr_en && wr_ready && (wr_addr == ADDR_W'(OFS_WORD));
  assign wr_cfg  = wr_en && wr_ready && (wr_addr == ADDR_W'(OFS_CFG));

  assert_no_same_cycle_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_en) |-> !rd_valid);

  assert_ready_single_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |=> !wr_ready);

  assert_hw_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_hw_ld && !wr_word) |=> (word_q == $past(word_hw_in)));

  assert_sw_priority_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_word && (wr_strb == '1)) |=> (word_q == $past(wr_data)));

  assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cfg |=> $stable(cfg_q));

  assert_kick_selfclear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    kick_pulse |=> !kick_pulse);

  assert_kick_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && ($past(rd_addr) == ADDR_W'(OFS_KICK))) |-> (rd_data == '0));

endmodule

bind ctl_regfile ctl_regfile_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .wr_en      (wr_en),
  .wr_strb    (wr_strb),
  .wr_ready   (wr_ready),
  .rd_addr    (rd_addr),
  .rd_en      (rd_en),
  .rd_data    (rd_data),
  .rd_valid   (rd_valid),
  .word_hw_in (word_hw_in),
  .word_hw_ld (word_hw_ld),
  .word_q     (word_q),
  .cfg_q      (cfg_q),
  .kick_pulse (kick_pulse)
);

// File: tb/test_ctl_regfile.sv
module test_ctl_regfile;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data, word_hw_in, word_q;
  logic        wr_en, wr_ready, rd_en, rd_valid, word_hw_ld, kick_pulse;
  logic [3:0]  wr_strb;
  logic [15:0] cfg_q;
  logic [7:0]  state_hw_in;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  ctl_regfile i_ctl_regfile (
    .clk(clk), .rst_n(rst_n),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en), .wr_strb(wr_strb), .wr_ready(wr_ready),
    .rd_addr(rd_addr), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .word_hw_in(word_hw_in), .word_hw_ld(word_hw_ld), .word_q(word_q), .cfg_q(cfg_q),
    .state_hw_in(state_hw_in), .kick_pulse(kick_pulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [31:0] d, input logic [3:0] s);
    int waits = 0;
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_strb = s; wr_en = 1'b1;
    do begin @(negedge clk); waits++; end while (!wr_ready && waits < 20);
    check("R3 wr_ready latency", waits, 1);
    @(negedge clk);            // commit edge has passed
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
    int waits = 0;
    @(negedge clk);
    rd_addr = a; rd_en = 1'b1;
    do begin @(negedge clk); waits++; end while (!rd_valid && waits < 20);
    check("R2 rd_valid latency", waits, 1);
    d = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 word reset", word_q, 32'h0);
    check("R1 cfg reset", {16'h0, cfg_q}, 32'h0100);
    check("R1 strobes idle", {29'h0, kick_pulse, wr_ready, rd_valid}, 32'h0);
  endtask

  task automatic t_word_rw();
    logic [31:0] d;
    bus_write(16'h0000, 32'h1234_5678, 4'hF);
    bus_read(16'h0000, d);
    check("R3 word full write", d, 32'h1234_5678);
    bus_write(16'h0000, 32'hAABB_CCDD, 4'h6);
    bus_read(16'h0000, d);
    check("R4 strobe 0x6", d, 32'h12BB_CC78);
    bus_write(16'h0000, 32'h0000_00EE, 4'h1);
    check("R4 strobe 0x1", word_q, 32'h12BB_CCEE);
  endtask

  task automatic t_cfg();
    logic [31:0] d;
    bus_read(16'h0004, d);
    check("R7 cfg read reset", d, 32'h0000_0100);
    bus_write(16'h0004, 32'hFFFF_FFFF, 4'hF);
    bus_read(16'h0004, d);
    check("R7 cfg upper bits zero", d, 32'h0000_FFFF);
    bus_write(16'h0004, 32'h0000_5500, 4'h2);
    check("R7 cfg byte1 only", {16'h0, cfg_q}, 32'h0000_55FF);
  endtask

  task automatic t_state();
    logic [31:0] d;
    state_hw_in = 8'h5A;
    bus_write(16'h0008, 32'hFFFF_FFFF, 4'hF);
    bus_read(16'h0008, d);
    check("R8 state read", d, 32'h0000_005A);
    check("R8 write no effect word", word_q, 32'h12BB_CCEE);
    check("R8 write no effect cfg", {16'h0, cfg_q}, 32'h0000_55FF);
  endtask

  task automatic t_kick();
    logic [31:0] d;
    bus_write(16'h0100, 32'h1, 4'h1);
    check("R9 kick high after write", {31'h0, kick_pulse}, 32'h1);
    @(negedge clk);
    check("R9 kick self-clear", {31'h0, kick_pulse}, 32'h0);
    bus_write(16'h0100, 32'h0, 4'h1);
    check("R9 write 0 no pulse", {31'h0, kick_pulse}, 32'h0);
    bus_write(16'h0100, 32'h1, 4'h2);
    check("R4 kick lane0 strobe off", {31'h0, kick_pulse}, 32'h0);
    bus_read(16'h0100, d);
    check("R9 kick reads zero", d, 32'h0);
  endtask

  task automatic t_hw_load();
    logic [31:0] d;
    @(negedge clk);
    word_hw_in = 32'hCAFE_0001; word_hw_ld = 1'b1;
    @(negedge clk);
    word_hw_ld = 1'b0;
    check("R5 hw load", word_q, 32'hCAFE_0001);
    word_hw_in = 32'h0BAD_0BAD;
    @(negedge clk);
    check("R5 no load when disabled", word_q, 32'hCAFE_0001);
    bus_read(16'h0000, d);
    check("R5 hw value on bus", d, 32'hCAFE_0001);
  endtask

  task automatic t_priority();
    @(negedge clk);
    word_hw_in = 32'hDEAD_0000; word_hw_ld = 1'b1;
    bus_write(16'h0000, 32'h0BAD_F00D, 4'hF);
    word_hw_ld = 1'b0;
    check("R6 software wins", word_q, 32'h0BAD_F00D);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    bus_read(16'h0010, d);
    check("R10 filler read", d, 32'h0);
    bus_write(16'h0010, 32'h7777_7777, 4'hF);
    bus_write(16'h0104, 32'h7777_7777, 4'hF);
    check("R10 write ignored word", word_q, 32'h0BAD_F00D);
    check("R10 write ignored cfg", {16'h0, cfg_q}, 32'h0000_55FF);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_addr = '0; rd_addr = '0;
    wr_data = '0; wr_strb = '0; word_hw_in = '0; word_hw_ld = 1'b0; state_hw_in = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_word_rw();
    t_cfg();
    t_state();
    t_kick();
    t_hw_load();
    t_priority();
    t_unmapped();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule